// File: doc/BRIEF.md
# Eight-input change latch with interrupt

This block watches eight digital inputs and records the first level change seen on each of them. Every input has two stored bits. The "new" bit keeps the level that was captured until the host reads it. The "old" bit keeps the level from before that capture. When an input that is not masked changes, the block drives an active-low change interrupt, sets a sticky status flag and raises a one-cycle reset-pulse request.

A host reads the block through a small strobe interface: a 2-bit register select, a read strobe that lasts one cycle, and registered read data. The same interface writes a control register that masks the upper four inputs. Reading the new bank moves its contents into the old bank and re-arms capture. Reading the status register clears the flag and releases the interrupt. A masked input keeps both of its stored bits equal to its live synchronised level.

Each input runs its own latch state machine, which has three states.

| Latch transition | From | To |
| --- | --- | --- |
| capture (unmasked change while armed) | `LT_ARMED` | `LT_HELD` |
| re-arm (read of the new bank) | `LT_HELD` | `LT_ARMED` |
| mask (the input's mask bit is set) | `LT_ARMED` or `LT_HELD` | `LT_TRACK` |
| unmask, levels equal | `LT_TRACK` | `LT_ARMED` |
| unmask, levels differ (capture) | `LT_TRACK` | `LT_HELD` |

A shared interrupt state machine has two states, `IRQ_IDLE` and `IRQ_PEND`.

| Interrupt transition | From | To |
| --- | --- | --- |
| raise (any capture) | `IRQ_IDLE` | `IRQ_PEND` |
| clear (status read with no capture in the same cycle) | `IRQ_PEND` | `IRQ_IDLE` |

Top module: `chg_latch_top`

## Requirements
- R1: While reset is active (synchronous, active low), the new and old banks load the synchronised input levels, and the following are set:
  - the status flag is cleared;
  - the control register is set to 0, so every input is unmasked;
  - `chg_n` is driven high;
  - `rp_req` is driven low;
  - `rd_data` is set to 0.
- R2: Each input passes through two synchroniser flops. An input level that is applied before clock edge k appears in the new bank at edge k+2. At that same edge `chg_n` goes low and the status flag is set.
- R3: A captured new bit ignores every later change of its input until the new bank is read.
- R4: The old bank keeps the level from before the capture. Reading the old bank changes no stored bit.
- R5: A read of the new bank copies each unmasked new bit into its old bit and re-arms capture. If the input already differs from the new bit, a fresh capture happens one edge later.
- R6: The status register reads as bit 0 = change flag, with bits 7:1 zero. A status read returns the flag as it was before the read, then clears the flag and drives `chg_n` high.
- R7: If a capture and a status read fall on the same edge, the capture wins. `chg_n` stays low and the flag stays set. The read returns the earlier flag value.
- R8: Control bit i (i = 0..3) masks input D(4+i). Control bits 7:4 are ignored on write and read as 0. Inputs D0 to D3 cannot be masked.
- R9: A masked input never drives `chg_n` low or `rp_req` high. Its old and new bits follow the live synchronised level on every cycle.
- R10: `rp_req` is high for exactly one cycle after each edge at which at least one unmasked capture occurs.
- R11: Register select values are 0 = new bank, 1 = old bank, 2 = status, 3 = control. `rd_data` updates at the edge of a `rd_stb` cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Monitored inputs D0..D7 (asynchronous) |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_sel | input | 2 | Register select: 0 new, 1 old, 2 status, 3 control |
| wr_stb | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Control write data; bits 3:0 are the masks for D4..D7 |
| rd_data | output | 8 | Registered read data |
| chg_n | output | 1 | Change interrupt, active low |
| rp_req | output | 1 | One-cycle reset-pulse request |

## Verification
Two pairs of functions can meet on the same clock edge. The first pair is a status read and a new capture. The bench changes an input, waits the two synchroniser edges, and then strobes a status read so that it lands on the capture edge. It judges the result by the returned value, which is the old flag, and by `chg_n`, which stays low. The second pair is a read of the new bank and a pending input difference. Its result is judged by the old bank, which takes the pre-read new value, and by the new bank, which takes a fresh capture one edge later.

// File: rtl/chg_pkg.sv
package chg_pkg;

    // Per-input latch states
    typedef enum logic [1:0] {
        LT_ARMED = 2'd0,
        LT_HELD  = 2'd1,
        LT_TRACK = 2'd2
    } latch_st_e;

    // Interrupt states
    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_st_e;

    // Register select encoding
    typedef enum logic [1:0] {
        SEL_NEW  = 2'd0,
        SEL_OLD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } rsel_e;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/chg_cell.sv
module chg_cell
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic mask_i,
    input  logic rd_new_i,
    output logic new_o,
    output logic old_o,
    output logic evt_o,
    output logic held_o
);

    latch_st_e st_q, st_d;
    logic      diff;

    assign diff   = (sync_i != new_o);
    assign evt_o  = !mask_i && (st_q != LT_HELD) && diff;
    assign held_o = (st_q == LT_HELD);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LT_ARMED: begin
                if (mask_i)    st_d = LT_TRACK;
                else if (diff) st_d = LT_HELD;
            end
            LT_HELD: begin
                if (mask_i)        st_d = LT_TRACK;
                else if (rd_new_i) st_d = LT_ARMED;
            end
            LT_TRACK: begin
                if (!mask_i) st_d = diff ? LT_HELD : LT_ARMED;
            end
            default: st_d = LT_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LT_ARMED;
        else        st_q <= st_d;
    end

    // Stored bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_o <= sync_i;
            old_o <= sync_i;
        end else if (mask_i) begin
            new_o <= sync_i;
            old_o <= sync_i;
        end else begin
            if (rd_new_i) old_o <= new_o;
            if (evt_o)    new_o <= sync_i;
        end
    end

endmodule

// File: rtl/chg_irq.sv
module chg_irq
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic stat_rd_i,
    output logic chg_n_o,
    output logic rp_o,
    output logic stat_o
);

    irq_st_e st_q, st_d;

    // Next-state logic: a capture in the same cycle beats a status read
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: if (evt_i) st_d = IRQ_PEND;
            IRQ_PEND: if (stat_rd_i && !evt_i) st_d = IRQ_IDLE;
            default:  st_d = IRQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) rp_o <= 1'b0;
        else        rp_o <= evt_i;
    end

    assign chg_n_o = (st_q == IRQ_IDLE);
    assign stat_o  = (st_q == IRQ_PEND);

endmodule

// File: rtl/chg_latch_top.sv
module chg_latch_top
    import chg_pkg::*;
#(
    parameter int N_IN        = 8,
    parameter int N_MASK      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] din,
    input  logic            rd_stb,
    input  logic [1:0]      rd_sel,
    input  logic            wr_stb,
    input  logic [N_IN-1:0] wr_data,
    output logic [N_IN-1:0] rd_data,
    output logic            chg_n,
    output logic            rp_req
);

    localparam int MASK_LO = N_IN - N_MASK;

    logic [N_IN-1:0]   sync_vec;
    logic [N_IN-1:0]   new_vec;
    logic [N_IN-1:0]   old_vec;
    logic [N_IN-1:0]   evt_vec;
    logic [N_IN-1:0]   held_vec;
    logic [N_IN-1:0]   mask_vec;
    logic [N_MASK-1:0] ctrl_q;
    logic              any_evt;
    logic              rd_new;
    logic              stat_rd;
    logic              stat_bit;

    assign rd_new  = rd_stb && (rsel_e'(rd_sel) == SEL_NEW);
    assign stat_rd = rd_stb && (rsel_e'(rd_sel) == SEL_STAT);
    assign any_evt = |evt_vec;

    chg_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (din),
        .q   (sync_vec)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_cell
        if (i >= MASK_LO) begin : g_mk
            assign mask_vec[i] = ctrl_q[i-MASK_LO];
        end else begin : g_nm
            assign mask_vec[i] = 1'b0;
        end

        chg_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_vec[i]),
            .mask_i   (mask_vec[i]),
            .rd_new_i (rd_new),
            .new_o    (new_vec[i]),
            .old_o    (old_vec[i]),
            .evt_o    (evt_vec[i]),
            .held_o   (held_vec[i])
        );
    end

    chg_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (any_evt),
        .stat_rd_i (stat_rd),
        .chg_n_o   (chg_n),
        .rp_o      (rp_req),
        .stat_o    (stat_bit)
    );

    // Control register (mask bits only)
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_stb) ctrl_q <= wr_data[N_MASK-1:0];
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            unique case (rsel_e'(rd_sel))
                SEL_NEW:  rd_data <= new_vec;
                SEL_OLD:  rd_data <= old_vec;
                SEL_STAT: rd_data <= {{(N_IN-1){1'b0}}, stat_bit};
                SEL_CTRL: rd_data <= {{(N_IN-N_MASK){1'b0}}, ctrl_q};
                default:  rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/chg_latch_chk.sv
module chg_latch_chk #(
    parameter int N_IN   = 8,
    parameter int N_MASK = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_stb,
    input logic [1:0]      rd_sel,
    input logic [N_IN-1:0] rd_data,
    input logic            chg_n,
    input logic            rp_req,
    input logic            any_evt,
    input logic [N_IN-1:0] held_v,
    input logic [N_IN-1:0] new_v,
    input logic [N_IN-1:0] mask_v
);

    // R1
    rst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chg_n && !rp_req));

    // R2
    evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> !chg_n);

    // R6
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == 2'd2 && !any_evt) |=> chg_n);

    // R8
    ctrl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == 2'd3) |=> (rd_data[N_IN-1:N_MASK] == '0));

    // R10
    rp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> rp_req);

    // R10
    rp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> !rp_req);

    for (genvar i = 0; i < N_IN; i++) begin : g_bit
        // R3
        hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (held_v[i] && !mask_v[i]) |=> $stable(new_v[i]));

        // R9
        mask_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_v[i] |=> !held_v[i]);
    end

endmodule

bind chg_latch_top chg_latch_chk #(.N_IN(N_IN), .N_MASK(N_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .chg_n   (chg_n),
    .rp_req  (rp_req),
    .any_evt (any_evt),
    .held_v  (held_vec),
    .new_v   (new_vec),
    .mask_v  (mask_vec)
);

// File: tb/sim_chg_latch_top.sv
module sim_chg_latch_top;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'hA5;
    logic       rd_stb = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       chg_n;
    logic       rp_req;

    int tests = 0;
    int fails = 0;
    int rp_cnt = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    chg_latch_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .rd_stb  (rd_stb),
        .rd_sel  (rd_sel),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .chg_n   (chg_n),
        .rp_req  (rp_req)
    );

    // Behavioural reference model, advanced at each rising edge
    bit [7:0] m_s1, m_s2, m_new, m_old, m_held, m_rd;
    bit [3:0] m_ctrl;
    bit       m_stat, m_chg = 1'b1, m_rp;

    always @(posedge clk) begin
        bit [7:0] sp;
        bit       ev;
        bit       masked;
        sp = m_s2;
        ev = 0;
        if (!rst_n) begin
            m_new = sp; m_old = sp; m_held = 0;
            m_ctrl = 0; m_stat = 0; m_chg = 1; m_rp = 0; m_rd = 0;
        end else begin
            if (rd_stb) begin
                case (rd_sel)
                    2'd0: m_rd = m_new;
                    2'd1: m_rd = m_old;
                    2'd2: m_rd = {7'd0, m_stat};
                    default: m_rd = {4'd0, m_ctrl};
                endcase
            end
            for (int i = 0; i < 8; i++) begin
                masked = (i >= 4) && m_ctrl[i-4];
                if (masked) begin
                    m_new[i] = sp[i]; m_old[i] = sp[i]; m_held[i] = 0;
                end else begin
                    bit cap;
                    cap = !m_held[i] && (sp[i] != m_new[i]);
                    if (rd_stb && rd_sel == 2'd0) begin
                        m_old[i] = m_new[i];
                        m_held[i] = 0;
                    end
                    if (cap) begin
                        m_new[i] = sp[i]; m_held[i] = 1; ev = 1;
                    end
                end
            end
            if (ev) begin
                m_stat = 1; m_chg = 0;
            end else if (rd_stb && rd_sel == 2'd2) begin
                m_stat = 0; m_chg = 1;
            end
            m_rp = ev;
            if (wr_stb) m_ctrl = wr_data[3:0];
        end
        m_s2 = m_s1;
        m_s1 = din;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 chg_n vs model", {7'd0, chg_n}, {7'd0, m_chg});
            check("R10 rp_req vs model", {7'd0, rp_req}, {7'd0, m_rp});
            check("R11 rd_data vs model", rd_data, m_rd);
        end
        if (rp_req) rp_cnt++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d;
        wr_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int rp0;
        tick(5);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 chg_n after reset", {7'd0, chg_n}, 8'h01);
        check("R1 rd_data after reset", rd_data, 8'h00);
        do_read(2'd0, v); check("R1 new bank loads inputs", v, 8'hA5);
        do_read(2'd1, v); check("R1 old bank loads inputs", v, 8'hA5);
        do_read(2'd2, v); check("R1 status cleared", v, 8'h00);
        do_read(2'd3, v); check("R1 control cleared", v, 8'h00);

        // R2 capture timing on D0
        rp0 = rp_cnt;
        din = 8'hA4;
        tick(2);
        check("R2 chg_n still high before capture edge", {7'd0, chg_n}, 8'h01);
        tick(1);
        check("R2 chg_n low at capture edge", {7'd0, chg_n}, 8'h00);
        tick(1);
        check("R10 one rp_req pulse per capture", rp_cnt - rp0, 1);
        do_read(2'd1, v); check("R4 old keeps pre-change level", v, 8'hA5);
        do_read(2'd1, v); check("R4 old read has no effect", v, 8'hA5);

        // R3 held latch ignores a later change
        din = 8'hA5;
        tick(4);
        do_read(2'd0, v); check("R3 new bit held until read", v, 8'hA4);
        // R5 read moved new into old; pending difference recaptures
        do_read(2'd1, v); check("R5 old took new on read", v, 8'hA4);
        do_read(2'd0, v); check("R5 fresh capture after re-arm", v, 8'hA5);
        do_read(2'd1, v); check("R5 old follows second read", v, 8'hA5);

        // R6 status read and clear
        do_read(2'd2, v); check("R6 status flag set", v, 8'h01);
        check("R6 chg_n released", {7'd0, chg_n}, 8'h01);
        do_read(2'd2, v); check("R6 status cleared by read", v, 8'h00);

        // R7 capture and status read on the same edge
        din = 8'hA7;
        tick(2);
        do_read(2'd2, v); check("R7 read returns earlier flag", v, 8'h00);
        check("R7 capture wins over clear", {7'd0, chg_n}, 8'h00);
        do_read(2'd2, v); check("R7 flag kept set", v, 8'h01);
        check("R6 chg_n high after clearing read", {7'd0, chg_n}, 8'h01);

        // R8 control write: upper bits ignored; mask D4, D5
        do_write(8'hF3);
        do_read(2'd3, v); check("R8 control bits 7:4 read zero", v, 8'h03);

        // R9 masked inputs track and stay silent
        rp0 = rp_cnt;
        din = 8'h97;
        tick(5);
        check("R9 masked change leaves chg_n high", {7'd0, chg_n}, 8'h01);
        check("R9 masked change gives no rp_req", rp_cnt - rp0, 0);
        do_read(2'd1, v); check("R9 old bank tracks masked inputs", v, 8'h95);
        do_read(2'd0, v); check("R9 new bank tracks masked inputs", v, 8'h97);
        do_read(2'd2, v); check("R9 no status from masked change", v, 8'h00);

        // R8 D0 cannot be masked
        din = 8'h96;
        tick(3);
        check("R8 unmaskable D0 raises chg_n", {7'd0, chg_n}, 8'h00);
        do_write(8'h00);
        do_read(2'd2, v); check("R6 status after D0 change", v, 8'h01);

        // R11 read data holds without a strobe
        do_read(2'd0, v); check("R11 new bank read", v, 8'h96);
        tick(3);
        check("R11 rd_data holds between reads", rd_data, 8'h96);

        tick(2);
        finish_run();
    end

endmodule